// File: doc/BRIEF.md
# In-Frame Response Transmit Sequencer

This block sends the in-frame response portion of a message on a byte-oriented serial link. The host raises a response request, writes response bytes into a one-byte holding register and, once the final byte is queued, asks for end-of-data. The sequencer moves each held byte into a shift register and offers it, most significant bit first, to a bit-level transmitter over a valid/ready handshake. After the last byte it offers a single end-of-data symbol. No CRC is appended.

Each accepted bit slot carries an arbitration-lost flag from the transmitter. When the flag is set, the response is abandoned: the request drops, and neither the interrupted byte nor any byte still held is resent. If the loss falls on one of the final two bits of a byte, two logic-1 bits are driven first. This creates a byte-boundary fault for listeners. Once the receive side has reported end-of-data for the current frame, a new response request is refused until the next frame begins.

Top module: `ifr_tx_seq`

## Requirements
- R1: After reset, `req_bit`, `bit_valid`, `done` and `abort` are 0 and `tde` is 1.
- R2: The bits of each response byte are offered on `bit_data` with `bit_sym_eod` = 0, most significant bit first.
- R3: `tde` goes to 0 on the clock edge that captures a `data_wr`. It returns to 1 when the held byte moves into the shift register.
- R4: When end-of-data has been requested and no byte is held after the last bit of a byte, the next slot has `bit_sym_eod` = 1. Its acceptance gives a one-cycle `done` pulse and clears `req_bit`.
- R5: A byte written while the previous byte is shifting is offered directly after that byte's last bit, with no gap slot.
- R6: No slot follows the end-of-data symbol: `bit_valid` stays 0 until a new request and byte arrive, so no CRC is sent.
- R7: A `req_set` arriving on or after an `eod_seen` pulse, and before the next `frame_sof`, leaves `req_bit` at 0, and no bit is offered. After `frame_sof` the request is accepted again.
- R8: Arbitration loss on bits 0 to DW-3 of a byte (counted from the first bit sent) does three things at once. It pulses `abort` at the accepting edge, clears `req_bit`, and discards any held byte (`tde` = 1). No further slot is offered.
- R9: Arbitration loss on either of the last two bits of a byte clears `req_bit`. Exactly two further slots follow, each with `bit_data` = 1 and `bit_sym_eod` = 0. `abort` pulses when the second of them is accepted.
- R10: While `bit_valid` is 1 and `bit_ready` is 0, `bit_valid`, `bit_data` and `bit_sym_eod` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_set | input | 1 | Host pulse requesting a response |
| eod_set | input | 1 | Host pulse requesting end-of-data after held bytes |
| data_wr | input | 1 | Host write strobe for the holding register |
| data_in | input | DW | Response byte written by the host |
| eod_seen | input | 1 | Receive side saw end-of-data on the bus |
| frame_sof | input | 1 | Receive side saw a new frame start |
| req_bit | output | 1 | Response request currently active |
| tde | output | 1 | Holding register empty |
| bit_valid | output | 1 | A slot is offered to the bit transmitter |
| bit_data | output | 1 | Bit value of the offered slot |
| bit_sym_eod | output | 1 | Offered slot is the end-of-data symbol |
| bit_ready | input | 1 | Bit transmitter completes the offered slot |
| bit_lost | input | 1 | Arbitration lost in the completed slot |
| done | output | 1 | One-cycle pulse: response finished normally |
| abort | output | 1 | One-cycle pulse: response abandoned |

## Verification
Every byte value from 0 to 255 is sent as a single-byte response, with transmitter stalls that vary. A sequencer that shifted from the wrong end or let a stalled slot change value would produce a miscompare. Arbitration loss is injected at each of the eight bit positions, with a second byte held. A mistake at the boundary between the early and late windows would either leave out the two forced ones or add them where they do not belong, and failing to discard the held byte would lead to a retry. A late request after end-of-data is checked to stay refused until a frame start, and a three-byte back-to-back response is checked for gaps or a missing end-of-data symbol.

// File: rtl/ifr_tx_seq.sv
module ifr_tx_seq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_set,
  input  logic          eod_set,
  input  logic          data_wr,
  input  logic [DW-1:0] data_in,
  input  logic          eod_seen,
  input  logic          frame_sof,
  output logic          req_bit,
  output logic          tde,
  output logic          bit_valid,
  output logic          bit_data,
  output logic          bit_sym_eod,
  input  logic          bit_ready,
  input  logic          bit_lost,
  output logic          done,
  output logic          abort
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  typedef enum logic [2:0] {IDLE, SHIFT, WAITB, EODS, XTRA} st_t;

  st_t           st;
  logic [DW-1:0] dreg, shreg;
  logic [CW-1:0] cnt;
  logic          xcnt, eod_req, blocked;

  assign bit_valid   = (st == SHIFT) || (st == EODS) || (st == XTRA);
  assign bit_data    = (st == XTRA) ? 1'b1 : ((st == SHIFT) ? shreg[DW-1] : 1'b0);
  assign bit_sym_eod = (st == EODS);

  wire xfer    = bit_valid && bit_ready;
  wire last    = (cnt == CW'(DW-1));
  wire late    = (cnt >= CW'(DW-2));
  wire lost    = (st == SHIFT) && xfer && bit_lost;
  wire move    = (st == IDLE  && req_bit && !tde) ||
                 (st == SHIFT && xfer && !bit_lost && last && !tde) ||
                 (st == WAITB && !tde);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; dreg <= '0; shreg <= '0; cnt <= '0; xcnt <= 1'b0;
      req_bit <= 1'b0; eod_req <= 1'b0; blocked <= 1'b0; tde <= 1'b1;
      done <= 1'b0; abort <= 1'b0;
    end else begin
      done  <= 1'b0;
      abort <= 1'b0;
      if (frame_sof) blocked <= 1'b0;
      else if (eod_seen) blocked <= 1'b1;
      if (req_set && !blocked && !eod_seen) req_bit <= 1'b1;
      if (eod_set && req_bit) eod_req <= 1'b1;
      if (data_wr) dreg <= data_in;
      if (data_wr) tde <= 1'b0;
      else if (move || lost) tde <= 1'b1;
      if (move) begin
        shreg <= dreg;
        cnt   <= '0;
      end
      case (st)
        IDLE: if (move) st <= SHIFT;
        SHIFT: if (xfer) begin
          if (bit_lost) begin
            req_bit <= 1'b0;
            eod_req <= 1'b0;
            if (late) begin
              st   <= XTRA;
              xcnt <= 1'b0;
            end else begin
              st    <= IDLE;
              abort <= 1'b1;
            end
          end else if (last) begin
            if (!tde)        st <= SHIFT;
            else if (eod_req) st <= EODS;
            else             st <= WAITB;
          end else begin
            shreg <= shreg << 1;
            cnt   <= cnt + 1'b1;
          end
        end
        WAITB: begin
          if (move) st <= SHIFT;
          else if (eod_req || eod_set) st <= EODS;
        end
        EODS: if (xfer) begin
          st      <= IDLE;
          done    <= 1'b1;
          req_bit <= 1'b0;
          eod_req <= 1'b0;
        end
        XTRA: if (xfer) begin
          if (xcnt) begin
            st    <= IDLE;
            abort <= 1'b1;
          end else xcnt <= 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module ifr_tx_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_bit,
  input logic tde,
  input logic data_wr,
  input logic frame_sof,
  input logic bit_valid,
  input logic bit_data,
  input logic bit_sym_eod,
  input logic bit_ready,
  input logic done,
  input logic abort,
  input logic blocked
);
  a_r10_hold_slot: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && !bit_ready |=> bit_valid && $stable(bit_data) && $stable(bit_sym_eod));
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_quiet_after_eod: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bit_valid && !req_bit);
  a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !req_bit && !bit_valid && !done);
  a_r7_refuse_late: assert property (@(posedge clk) disable iff (!rst_n)
    blocked && !req_bit |=> !req_bit);
  a_r3_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !tde);
endmodule

bind ifr_tx_seq ifr_tx_seq_chk u_chk (.*);

// File: tb/tb_ifr_tx_seq.sv
module tb_ifr_tx_seq;
  logic clk = 0, rst_n = 0;
  logic req_set = 0, eod_set = 0, data_wr = 0, eod_seen = 0, frame_sof = 0;
  logic bit_ready = 0, bit_lost = 0;
  logic [7:0] data_in = 0;
  logic req_bit, tde, bit_valid, bit_data, bit_sym_eod, done, abort;
  int nchk = 0, nfail = 0, cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ifr_tx_seq #(.DW(8)) dut (.*);

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic host_wr(input logic [7:0] b);
    data_in = b; data_wr = 1; tick; data_wr = 0;
  endtask
  task automatic host_req; req_set = 1; tick; req_set = 0; endtask
  task automatic host_eod; eod_set = 1; tick; eod_set = 0; endtask

  task automatic slot(input bit lost, input int stall,
                      output bit d, output bit s, output bit dn, output bit ab, output bit got);
    int w = 0;
    while (!bit_valid && w < 40) begin tick; w++; end
    got = bit_valid; d = bit_data; s = bit_sym_eod;
    for (int k = 0; k < stall; k++) begin
      tick;
      chk(bit_valid && bit_data == d && bit_sym_eod == s, "R10 stalled slot changed", {bit_valid, bit_data, bit_sym_eod}, {1'b1, d, s});
    end
    bit_ready = 1; bit_lost = lost; tick;
    bit_ready = 0; bit_lost = 0;
    dn = done; ab = abort;
  endtask

  task automatic quiet(input int n, input string r);
    for (int k = 0; k < n; k++) begin
      tick;
      chk(!bit_valid, r, bit_valid, 0);
    end
  endtask

  initial begin
    bit d, s, dn, ab, got;
    logic [7:0] mb [3];
    repeat (3) tick;
    rst_n = 1; tick;
    chk(!req_bit && !bit_valid && !done && !abort && tde, "R1 reset state",
        {req_bit, bit_valid, done, abort, tde}, 5'b00001);

    for (int b = 0; b < 256; b++) begin
      logic [7:0] bb = 8'(b);
      host_wr(bb);
      chk(tde == 0, "R3 tde after write", tde, 0);
      host_req; host_eod;
      for (int i = 0; i < 8; i++) begin
        slot(0, (i == 0) ? b % 3 : 0, d, s, dn, ab, got);
        chk(got && d == bb[7-i] && !s, "R2 bit order", {got, d, s}, {1'b1, bb[7-i], 1'b0});
        if (i == 0) chk(tde == 1, "R3 tde after move", tde, 1);
      end
      slot(0, b % 2, d, s, dn, ab, got);
      chk(got && s && dn && !ab, "R4 eod symbol and done", {got, s, dn, ab}, 4'b1110);
      chk(!req_bit, "R4 request cleared", req_bit, 0);
      quiet(4, "R6 slot after eod");
    end

    mb[0] = 8'h3A; mb[1] = 8'hC5; mb[2] = 8'h0F;
    host_wr(mb[0]); host_req;
    for (int k = 0; k < 3; k++)
      for (int i = 0; i < 8; i++) begin
        slot(0, 0, d, s, dn, ab, got);
        chk(got && d == mb[k][7-i] && !s, "R5 back-to-back byte", {got, d, s}, {1'b1, mb[k][7-i], 1'b0});
        if (i == 0 && k < 2) host_wr(mb[k+1]);
        if (i == 0 && k == 2) host_eod;
      end
    slot(0, 0, d, s, dn, ab, got);
    chk(got && s && dn, "R5 eod after three bytes", {got, s, dn}, 3'b111);
    quiet(4, "R6 slot after eod");

    for (int pos = 0; pos < 8; pos++) begin
      logic [7:0] ab8 = 8'h5A;
      host_wr(ab8); host_req;
      while (!tde) tick;
      host_wr(8'hE7);
      for (int i = 0; i < pos; i++) begin
        slot(0, 0, d, s, dn, ab, got);
        chk(got && d == ab8[7-i], "R8 bit before loss", d, ab8[7-i]);
      end
      slot(1, 0, d, s, dn, ab, got);
      if (pos < 6) begin
        chk(ab && !dn, "R8 abort on early loss", {ab, dn}, 2'b10);
        chk(!req_bit && tde, "R8 request cleared and byte dropped", {req_bit, tde}, 2'b01);
        quiet(10, "R8 retry after loss");
      end else begin
        chk(!ab && !req_bit, "R9 no abort before extra bits", {ab, req_bit}, 0);
        slot(0, 1, d, s, dn, ab, got);
        chk(got && d && !s && !ab, "R9 first extra one", {got, d, s, ab}, 4'b1100);
        slot(0, 0, d, s, dn, ab, got);
        chk(got && d && !s && ab, "R9 second extra one and abort", {got, d, s, ab}, 4'b1101);
        chk(tde, "R9 held byte dropped", tde, 1);
        quiet(10, "R9 slot after extra bits");
      end
    end

    eod_seen = 1; tick; eod_seen = 0;
    host_wr(8'h77); host_req;
    chk(!req_bit, "R7 late request refused", req_bit, 0);
    quiet(10, "R7 bit after refused request");
    frame_sof = 1; tick; frame_sof = 0;
    host_req;
    chk(req_bit, "R7 request after frame start", req_bit, 1);
    host_eod;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v = 8'h77;
      slot(0, 0, d, s, dn, ab, got);
      chk(got && d == v[7-i] && !s, "R7 byte after frame start", d, v[7-i]);
    end
    slot(0, 0, d, s, dn, ab, got);
    chk(s && dn, "R7 eod after reopened request", {s, dn}, 2'b11);

    repeat (3) tick;
    finish_run();
  end
endmodule